// File: doc/BRIEF.md
# Register redirection table

This block keeps a small key-value table that renames 5-bit architectural register operands into a 7-bit register space. Each entry holds a key, a register-file selector, a redirected index, a vector flag and an element-width override code. A decoder presents an operand number together with the file it belongs to. The block answers in the same cycle with the redirected index, whether that register is a vector, and the width override that applies, if any.

Software fills the table through a 64-bit CSR port. Each window on that port shows four consecutive 16-bit entries, and neighbouring windows share two of them. A write replaces the entries in its window and zeroes every entry above it. A compiler or context-switch routine therefore writes the windows in rising order and never has to clear the tail by hand.

Top module: `regmap_cam`

## Requirements
- R1: An entry is laid out as bit 15 vector flag, bits 14..8 redirected index, bit 7 file selector, bits 6..5 width code, and bits 4..0 key. On a hit the lookup returns that entry's index, vector flag and width code.
- R2: An entry matches only when its key equals the operand number and its selector equals the requested file (1 = integer, 0 = floating point). A match raises `lk_hit`.
- R3: `lk_width` reports the element width forced by the width code: 00 gives 0 (no override), 01 gives 32, 10 gives 16 and 11 gives 8.
- R4: When no entry matches, `lk_hit` is 0, `lk_idx` is the operand zero-extended to 7 bits, `lk_vec` is 0, and `lk_wcode` and `lk_width` are 0.
- R5: An all-zero entry is empty and never matches.
- R6: When several entries match, the entry with the lowest index supplies the result.
- R7: A read of window w returns entries 2w, 2w+1, 2w+2 and 2w+3 in bits 15..0, 31..16, 47..32 and 63..48. The read is combinational.
- R8: A write to window w stores the four slices into those entries at the next clock edge. Before that edge, reads still show the old contents.
- R9: A write zeroes every entry with an index above 2w+3 and leaves the entries below 2w unchanged.
- R10: Slices of a window that fall beyond entry 15 read as zero, and writes to them are discarded.
- R11: A synchronous reset clears all entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_opnd | input | 5 | Operand number to look up |
| lk_is_int | input | 1 | 1 = integer file, 0 = floating-point file |
| lk_hit | output | 1 | An entry matched |
| lk_idx | output | 7 | Redirected register index |
| lk_vec | output | 1 | Register is a vector |
| lk_wcode | output | 2 | Width override code of the matching entry |
| lk_width | output | 6 | Forced element width in bits, 0 when not overridden |
| csr_win | input | 3 | CSR window number |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data for `csr_win` |

## Verification
After every table change, the lookup is swept over all 32 operands in both register files. This tells hits apart from misses, the integer side from the float side, the lowest duplicate from higher duplicates, and empty entries from real ones. The windows are written in rising order, then out of order, and then at the top window. Reading every window after each write shows the new contents, the zeroed tail, the untouched lower entries and the dead slices. A read taken just before the write edge confirms that the old contents are still visible.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  localparam int ENT_W = 16;
  localparam int KEY_W = 5;
  localparam int IDX_W = 7;
  localparam int WC_W  = 2;
  localparam int WB_W  = 6;

  typedef struct packed {
    logic             vec;
    logic [IDX_W-1:0] idx;
    logic             is_int;
    logic [WC_W-1:0]  wcode;
    logic [KEY_W-1:0] key;
  } rm_entry_t;

  function automatic logic [WB_W-1:0] wcode_bits(input logic [WC_W-1:0] c);
    case (c)
      2'b01:   return WB_W'(32);
      2'b10:   return WB_W'(16);
      2'b11:   return WB_W'(8);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/regmap_store.sv
module regmap_store
  import regmap_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int CSR_W = 64,
  parameter int WIN_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [WIN_W-1:0]       win,
  input  logic [CSR_W-1:0]       wdata,
  output logic [CSR_W-1:0]       rdata,
  output logic [N_ENT*ENT_W-1:0] tbl
);
  localparam int SLICES = CSR_W / ENT_W;
  localparam int STEP   = SLICES / 2;
  localparam int SL_W   = (SLICES > 1) ? $clog2(SLICES) : 1;

  logic [N_ENT*ENT_W-1:0] tbl_q;
  logic [N_ENT-1:0]       ent_nz;
  int                     base;

  assign base = int'(win) * STEP;
  assign tbl  = tbl_q;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic            in_win, above;
    logic [SL_W-1:0] slot;
    int              off;
    assign off    = e - base;
    assign slot   = off[SL_W-1:0];
    assign in_win = (e >= base) && (e < base + SLICES);
    assign above  = (e >= base + SLICES);
    assign ent_nz[e] = |tbl_q[e*ENT_W +: ENT_W];

    always_ff @(posedge clk) begin
      if (rst)
        tbl_q[e*ENT_W +: ENT_W] <= '0;
      else if (we && in_win)
        tbl_q[e*ENT_W +: ENT_W] <= wdata[slot*ENT_W +: ENT_W];
      else if (we && above)
        tbl_q[e*ENT_W +: ENT_W] <= '0;
    end
  end

  for (genvar s = 0; s < SLICES; s++) begin : g_rd
    int ri;
    assign ri = base + s;
    assign rdata[s*ENT_W +: ENT_W] = (ri < N_ENT) ? tbl_q[ri*ENT_W +: ENT_W] : '0;
  end

  // Helpers used by the checks below
  function automatic logic [CSR_W-1:0] win_view(input logic [N_ENT*ENT_W-1:0] t,
                                                input logic [WIN_W-1:0] w);
    logic [CSR_W-1:0] r;
    r = '0;
    for (int s = 0; s < SLICES; s++)
      if (int'(w) * STEP + s < N_ENT)
        r[s*ENT_W +: ENT_W] = t[(int'(w) * STEP + s)*ENT_W +: ENT_W];
    return r;
  endfunction

  function automatic logic [CSR_W-1:0] live_slices(input logic [WIN_W-1:0] w);
    logic [CSR_W-1:0] r;
    r = '0;
    for (int s = 0; s < SLICES; s++)
      if (int'(w) * STEP + s < N_ENT) r[s*ENT_W +: ENT_W] = '1;
    return r;
  endfunction

  function automatic logic [N_ENT-1:0] tail_of(input logic [WIN_W-1:0] w);
    logic [N_ENT-1:0] r;
    for (int e = 0; e < N_ENT; e++) r[e] = (e >= int'(w) * STEP + SLICES);
    return r;
  endfunction

  function automatic logic [N_ENT*ENT_W-1:0] head_bits(input logic [WIN_W-1:0] w);
    logic [N_ENT*ENT_W-1:0] r;
    for (int e = 0; e < N_ENT; e++)
      r[e*ENT_W +: ENT_W] = (e < int'(w) * STEP) ? '1 : '0;
    return r;
  endfunction

  // R8
  win_store_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> win_view(tbl_q, $past(win)) == ($past(wdata) & live_slices($past(win))));

  // R9
  tail_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (ent_nz & tail_of($past(win))) == '0);

  // R9
  head_keep_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> ((tbl_q ^ $past(tbl_q)) & head_bits($past(win))) == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(tbl_q));

  // R11
  reset_clear_chk: assert property (@(posedge clk) rst |=> ent_nz == '0);
endmodule

// File: rtl/regmap_match.sv
module regmap_match
  import regmap_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_ENT*ENT_W-1:0] tbl,
  input  logic [KEY_W-1:0]       opnd,
  input  logic                   is_int,
  output logic                   hit,
  output rm_entry_t              sel
);
  logic [N_ENT-1:0] cand;
  logic [N_ENT-1:0] pick_oh;

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    rm_entry_t ent;
    assign ent     = rm_entry_t'(tbl[e*ENT_W +: ENT_W]);
    assign cand[e] = (ent != '0) && (ent.key == opnd) && (ent.is_int == is_int);
  end

  // lowest set bit wins
  assign pick_oh = cand & (~cand + N_ENT'(1));
  assign hit     = |cand;

  always_comb begin
    sel = '0;
    for (int e = 0; e < N_ENT; e++)
      if (pick_oh[e]) sel = sel | rm_entry_t'(tbl[e*ENT_W +: ENT_W]);
  end

  // R6
  one_pick_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_oh) && (hit == (pick_oh != '0)));

  // R6
  lowest_pick_chk: assert property (@(posedge clk) disable iff (rst)
    ((pick_oh - N_ENT'(1)) & cand) == '0);

  // R2
  key_agree_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (sel.key == opnd) && (sel.is_int == is_int));

  // R5
  empty_skip_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> sel != '0);
endmodule

// File: rtl/regmap_cam.sv
module regmap_cam
  import regmap_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int CSR_W = 64,
  parameter int WIN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEY_W-1:0]  lk_opnd,
  input  logic              lk_is_int,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic              lk_vec,
  output logic [WC_W-1:0]   lk_wcode,
  output logic [WB_W-1:0]   lk_width,
  input  logic [WIN_W-1:0]  csr_win,
  input  logic              csr_we,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata
);
  logic [N_ENT*ENT_W-1:0] tbl;
  rm_entry_t              sel;
  logic                   hit;

  regmap_store #(.N_ENT(N_ENT), .CSR_W(CSR_W), .WIN_W(WIN_W)) i_store (
    .clk(clk), .rst(rst), .we(csr_we), .win(csr_win),
    .wdata(csr_wdata), .rdata(csr_rdata), .tbl(tbl)
  );

  regmap_match #(.N_ENT(N_ENT)) i_match (
    .clk(clk), .rst(rst), .tbl(tbl), .opnd(lk_opnd),
    .is_int(lk_is_int), .hit(hit), .sel(sel)
  );

  assign lk_hit   = hit;
  assign lk_idx   = hit ? sel.idx : {{(IDX_W-KEY_W){1'b0}}, lk_opnd};
  assign lk_vec   = hit & sel.vec;
  assign lk_wcode = hit ? sel.wcode : '0;
  assign lk_width = wcode_bits(lk_wcode);

  // R4
  miss_plain_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> !lk_vec && (lk_width == '0) && (lk_idx[KEY_W-1:0] == lk_opnd));

  // R3
  width_code_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_wcode == 2'b00) == (lk_width == '0));
endmodule

// File: tb/test_regmap_cam.sv
module test_regmap_cam;
  logic        clk = 0;
  logic        rst = 1;
  logic [4:0]  lk_opnd = '0;
  logic        lk_is_int = 0;
  logic        lk_hit;
  logic [6:0]  lk_idx;
  logic        lk_vec;
  logic [1:0]  lk_wcode;
  logic [5:0]  lk_width;
  logic [2:0]  csr_win = '0;
  logic        csr_we = 0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] m [16];

  always #5 clk = ~clk;

  regmap_cam i_regmap_cam (
    .clk(clk), .rst(rst), .lk_opnd(lk_opnd), .lk_is_int(lk_is_int),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_vec(lk_vec), .lk_wcode(lk_wcode),
    .lk_width(lk_width), .csr_win(csr_win), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  function automatic logic [15:0] ent(input bit v, input int idx, input bit fi,
                                      input int wc, input int key);
    return {v, idx[6:0], fi, wc[1:0], key[4:0]};
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model_win(input int w);
    logic [63:0] r = '0;
    for (int s = 0; s < 4; s++)
      if (2*w + s < 16) r[16*s +: 16] = m[2*w + s];
    return r;
  endfunction

  task automatic csr_write(input int w, input logic [63:0] d);
    @(negedge clk);
    csr_win = 3'(w); csr_wdata = d; csr_we = 1;
    #1 check(csr_rdata, model_win(w), "R8 old contents before edge");
    @(posedge clk);
    for (int e = 0; e < 16; e++) begin
      if (e >= 2*w && e < 2*w + 4) m[e] = d[16*(e - 2*w) +: 16];
      else if (e >= 2*w + 4) m[e] = '0;
    end
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic read_all(input string tag);
    for (int w = 0; w < 8; w++) begin
      csr_win = 3'(w);
      #1 check(csr_rdata, model_win(w), tag);
    end
  endtask

  task automatic sweep();
    for (int o = 0; o < 32; o++)
      for (int f = 0; f < 2; f++) begin
        logic        eh = 0;
        logic [15:0] ee = '0;
        logic [6:0]  ei;
        logic [5:0]  ew;
        for (int e = 15; e >= 0; e--)
          if (m[e] != 0 && m[e][4:0] == o[4:0] && m[e][7] == f[0]) begin
            eh = 1; ee = m[e];
          end
        ei = eh ? ee[14:8] : 7'(o);
        ew = (eh && ee[6:5] != 0) ? 6'(64 >> ee[6:5]) : 6'd0;
        lk_opnd = 5'(o); lk_is_int = f[0];
        #1 check({lk_hit, lk_idx, lk_vec, lk_wcode, lk_width},
                 {eh, ei, eh & ee[15], eh ? ee[6:5] : 2'b00, ew},
                 eh ? "R1 R2 R3 R6 lookup hit" : "R4 R5 lookup miss");
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 16; e++) m[e] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    read_all("R11 reset state");
    sweep();

    // R1 R2 R3 R5 R6: duplicate keys, both files, empty slot
    csr_write(0, {16'h0000, ent(0, 7'h7F, 1, 2, 3),
                  ent(0, 7'h12, 0, 1, 3), ent(1, 7'h45, 1, 3, 3)});
    read_all("R7 window 0");
    sweep();
    lk_opnd = 5'd3; lk_is_int = 1;
    #1 check({lk_idx, lk_width}, {7'h45, 6'd8}, "R6 lowest duplicate wins");
    lk_opnd = 5'd0; lk_is_int = 0;
    #1 check(lk_hit, 1'b0, "R5 empty entry no hit");

    csr_write(1, {ent(1, 7'h33, 0, 0, 31), ent(0, 7'h01, 0, 2, 9),
                  ent(1, 7'h20, 1, 1, 9), ent(0, 7'h50, 1, 0, 3)});
    csr_write(3, {ent(1, 7'h66, 1, 3, 7), ent(0, 7'h61, 0, 1, 8),
                  ent(1, 7'h62, 1, 2, 1), ent(0, 7'h63, 0, 3, 2)});
    read_all("R9 rising fill");
    sweep();
    lk_opnd = 5'd9; lk_is_int = 1;
    #1 check({lk_hit, lk_width}, {1'b1, 6'd32}, "R3 code 01 gives 32");

    // R9: lower window rewrite wipes entries 6..9
    csr_write(1, {ent(0, 7'h0A, 1, 0, 5), ent(0, 7'h0B, 0, 0, 6),
                  ent(0, 7'h0C, 1, 1, 7), ent(0, 7'h0D, 0, 2, 8)});
    read_all("R9 tail wiped head kept");
    csr_win = 3'd3;
    #1 check(csr_rdata, 64'h0, "R9 window 3 cleared");
    sweep();

    // R10: top window, dead slices
    csr_write(7, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_win = 3'd7;
    #1 check(csr_rdata, 64'h0000_0000_FFFF_FFFF, "R10 dead slices read zero");
    read_all("R10 lower entries kept");
    sweep();
    csr_write(6, {ent(1, 7'h44, 0, 2, 4), ent(0, 7'h45, 0, 0, 4),
                  ent(0, 7'h46, 1, 3, 4), ent(1, 7'h47, 1, 1, 4)});
    read_all("R9 top window rewrite");
    sweep();

    // R11: mid-run reset
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    for (int e = 0; e < 16; e++) m[e] = '0;
    read_all("R11 reset clears");
    sweep();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule